// File: doc/BRIEF.md
# Multi-Operand Prefix-Sum Unit

This block is a combining functional unit holding a small file of base registers. In every cycle any number of requesters may each present an increment aimed at one base. The unit treats all requests that arrive together as a single multi-operand prefix-sum that completes in one step, not as a queue of separate fetch-and-add operations.

Each requester receives the value its base held just before its own increment was added, in some serial order. The base then advances by the sum of every increment aimed at it. Callers may only rely on the result matching some consistent serial order. The unit does fix that order, lowest requester number first, so that results are repeatable.

A typical use passes increment 1 from many writers to hand out distinct, consecutive slot indices, for example when compacting the nonzero elements of an array. A controller can load any base directly during a cycle in which no request is presented. Sums wrap modulo 2^WIDTH.

Top module: `psum_combiner`

## Requirements
- R1: After a synchronous active-low reset, every base holds 0, every rsp_valid bit is 0 and every rsp_value lane is 0.
- R2: A lone request with increment e on base b returns the previous content of b, and b then holds that content plus e.
- R3: Requests on the same base in one cycle are chained in ascending requester index: a requester receives the old base plus the increments of all lower-numbered requesters on that base. The base ends at the old value plus all of them.
- R4: Requests on different bases in the same cycle are combined per base, each independently of the others.
- R5: rsp_valid bit i rises exactly one cycle after req_valid bit i was high and is low otherwise. rsp_value lane i (bits i*WIDTH upward) belongs to requester i, and req_base field i (bits i*SELW upward) selects its base.
- R6: With init_en high and no req_valid bit set, base init_sel is loaded with init_val at the clock edge.
- R7: An init_en in a cycle in which any req_valid bit is set is ignored, and the bases follow the requests only.
- R8: Base arithmetic and returned values wrap modulo 2^WIDTH.
- R9: With increment 1 from k requesters on one base, the returned values are the k consecutive values from the old base upward, all distinct, and the base ends k above its old value.
- R10: A base that no request targets and that no accepted init addresses keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | NREQ | Per-requester request strobe |
| req_base | input | NREQ*SELW | Per-requester base select, field i at bits i*SELW |
| req_inc | input | NREQ*WIDTH | Per-requester increment, lane i at bits i*WIDTH |
| init_en | input | 1 | Direct base load strobe, accepted only when no request is present |
| init_sel | input | SELW | Base to load |
| init_val | input | WIDTH | Value to load |
| rsp_valid | output | NREQ | Per-requester result valid, one cycle after the request |
| rsp_value | output | NREQ*WIDTH | Per-requester base value before its own increment |

## Verification
The bench builds the unit with four requesters, four bases and an 8-bit width. Four requesters are enough to put a full chain of four on one base, to split requests across several bases, and to leave gaps in the requester mask for a compaction pattern. The narrow width lets a single cycle push a base past 255, so the wrap rule is exercised directly. Four bases leave untouched registers that can be read back with zero increments.

// File: rtl/psum_combiner.sv
module psum_combiner #(
  parameter int NREQ  = 4,
  parameter int NBASE = 4,
  parameter int WIDTH = 16,
  localparam int SELW = (NBASE > 1) ? $clog2(NBASE) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NREQ-1:0]        req_valid,
  input  logic [NREQ*SELW-1:0]   req_base,
  input  logic [NREQ*WIDTH-1:0]  req_inc,
  input  logic                   init_en,
  input  logic [SELW-1:0]        init_sel,
  input  logic [WIDTH-1:0]       init_val,
  output logic [NREQ-1:0]        rsp_valid,
  output logic [NREQ*WIDTH-1:0]  rsp_value
);

  logic [NBASE-1:0][WIDTH-1:0] base_q, base_d;
  logic [NREQ-1:0][SELW-1:0]   sel;
  logic [NREQ-1:0][WIDTH-1:0]  inc;
  logic [NREQ-1:0][WIDTH-1:0]  pre;
  logic                        idle;

  assign sel  = req_base;
  assign inc  = req_inc;
  assign idle = (req_valid == '0);

  always_comb begin
    for (int i = 0; i < NREQ; i++) begin
      pre[i] = base_q[sel[i]];
      for (int j = 0; j < i; j++)
        if (req_valid[j] && sel[j] == sel[i])
          pre[i] = pre[i] + inc[j];
    end
  end

  always_comb begin
    for (int b = 0; b < NBASE; b++) begin
      base_d[b] = base_q[b];
      for (int j = 0; j < NREQ; j++)
        if (req_valid[j] && sel[j] == SELW'(b))
          base_d[b] = base_d[b] + inc[j];
      if (init_en && idle && init_sel == SELW'(b))
        base_d[b] = init_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q    <= '0;
      rsp_valid <= '0;
      rsp_value <= '0;
    end else begin
      base_q    <= base_d;
      rsp_valid <= req_valid;
      rsp_value <= pre;
    end
  end

endmodule

// File: rtl/psum_combiner_chk.sv
module psum_combiner_chk #(
  parameter int NREQ  = 4,
  parameter int NBASE = 4,
  parameter int WIDTH = 16,
  localparam int SELW = (NBASE > 1) ? $clog2(NBASE) : 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NREQ-1:0]             req_valid,
  input logic [NREQ*SELW-1:0]        req_base,
  input logic [NREQ*WIDTH-1:0]       req_inc,
  input logic                        init_en,
  input logic [SELW-1:0]             init_sel,
  input logic [WIDTH-1:0]            init_val,
  input logic [NREQ-1:0]             rsp_valid,
  input logic [NREQ*WIDTH-1:0]       rsp_value,
  input logic [NBASE-1:0][WIDTH-1:0] base_q
);

  logic [NBASE-1:0] touched;

  always_comb begin
    for (int b = 0; b < NBASE; b++) begin
      touched[b] = init_en && (req_valid == '0) && (init_sel == SELW'(b));
      for (int j = 0; j < NREQ; j++)
        if (req_valid[j] && req_base[j*SELW +: SELW] == SELW'(b))
          touched[b] = 1'b1;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (rsp_valid == '0 && base_q == '0));

  assert_rsp_timing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rsp_valid == $past(req_valid));

  assert_lowest_gets_old_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid[0] |=> rsp_value[WIDTH-1:0] == $past(base_q[req_base[SELW-1:0]]));

  assert_init_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (init_en && req_valid == '0) |=> base_q[$past(init_sel)] == $past(init_val));

  for (genvar b = 0; b < NBASE; b++) begin : g_hold
    assert_base_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !touched[b] |=> $stable(base_q[b]));
  end

endmodule

bind psum_combiner psum_combiner_chk #(.NREQ(NREQ), .NBASE(NBASE), .WIDTH(WIDTH)) u_chk (.*);

// File: tb/tb_psum_combiner.sv
`timescale 1ns/1ps
module tb_psum_combiner;
  localparam int NREQ = 4, NBASE = 4, W = 8, SW = 2;

  logic clk = 0, rst_n = 0;
  logic [NREQ-1:0]    req_valid = '0;
  logic [NREQ*SW-1:0] req_base  = '0;
  logic [NREQ*W-1:0]  req_inc   = '0;
  logic               init_en   = 0;
  logic [SW-1:0]      init_sel  = '0;
  logic [W-1:0]       init_val  = '0;
  logic [NREQ-1:0]    rsp_valid;
  logic [NREQ*W-1:0]  rsp_value;

  psum_combiner #(.NREQ(NREQ), .NBASE(NBASE), .WIDTH(W)) dut (.*);

  always #10 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [W-1:0] mb [NBASE];
  logic [NREQ-1:0]   qm [$];
  logic [NREQ*W-1:0] qv [$];
  string             qt [$];

  task automatic op(input logic [NREQ-1:0] v, input logic [NREQ*SW-1:0] s,
                    input logic [NREQ*W-1:0] inc, input bit ie,
                    input logic [SW-1:0] is, input logic [W-1:0] iv, input string tag);
    logic [NREQ*W-1:0] ev;
    ev = '0;
    @(negedge clk);
    req_valid = v; req_base = s; req_inc = inc;
    init_en = ie; init_sel = is; init_val = iv;
    for (int i = 0; i < NREQ; i++) begin
      if (v[i]) begin
        ev[i*W +: W] = mb[int'(s[i*SW +: SW])];
        mb[int'(s[i*SW +: SW])] = mb[int'(s[i*SW +: SW])] + inc[i*W +: W];
      end
    end
    if (ie && v == '0) mb[int'(is)] = iv;
    qm.push_back(v); qv.push_back(ev); qt.push_back(tag);
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    req_valid = '0; init_en = 0;
  endtask

  // read every base with zero increments, requester i reads base i
  task automatic read_all(input string tag);
    op(4'b1111, {2'd3, 2'd2, 2'd1, 2'd0}, '0, 0, '0, '0, tag);
  endtask

  always @(posedge clk) begin
    if (rst_n && qm.size() > 0) begin
      logic [NREQ-1:0] m;
      logic [NREQ*W-1:0] v;
      string t;
      m = qm.pop_front(); v = qv.pop_front(); t = qt.pop_front();
      #5;
      tests++;
      if (rsp_valid !== m) begin
        fails++;
        $display("FAIL %s (R5) rsp_valid got %b exp %b", t, rsp_valid, m);
      end
      for (int i = 0; i < NREQ; i++) begin
        if (m[i]) begin
          tests++;
          if (rsp_value[i*W +: W] !== v[i*W +: W]) begin
            fails++;
            $display("FAIL %s req%0d value got %0d exp %0d", t, i,
                     rsp_value[i*W +: W], v[i*W +: W]);
          end
        end
      end
    end
  end

  initial begin
    for (int b = 0; b < NBASE; b++) mb[b] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    tests++;
    if (rsp_valid !== '0 || rsp_value !== '0) begin
      fails++;
      $display("FAIL R1 reset outputs got %b/%h exp 0/0", rsp_valid, rsp_value);
    end
    read_all("R1 bases zero");
    op(4'b0001, {2'd0, 2'd0, 2'd0, 2'd1}, {8'd0, 8'd0, 8'd0, 8'd5}, 0, 0, 0, "R2 single");
    op(4'b0010, {2'd0, 2'd0, 2'd1, 2'd0}, {8'd0, 8'd0, 8'd3, 8'd0}, 0, 0, 0, "R2 readback");
    op(4'b1111, {2'd2, 2'd2, 2'd2, 2'd2}, {8'd4, 8'd3, 8'd2, 8'd1}, 0, 0, 0, "R3 chain");
    read_all("R3 base total");
    op(4'b1111, {2'd1, 2'd3, 2'd1, 2'd3}, {8'd7, 8'd9, 8'd11, 8'd13}, 0, 0, 0, "R4 split");
    read_all("R4 R10 per-base");
    op(4'b0000, '0, '0, 1, 2'd3, 8'd200, "R6 init");
    read_all("R6 init readback");
    op(4'b0001, {2'd0, 2'd0, 2'd0, 2'd0}, {8'd0, 8'd0, 8'd0, 8'd2}, 1, 2'd1, 8'd99, "R7 init with request");
    read_all("R7 init ignored");
    op(4'b0011, {2'd0, 2'd0, 2'd3, 2'd3}, {8'd0, 8'd0, 8'd40, 8'd60}, 0, 0, 0, "R8 wrap");
    read_all("R8 wrapped base");
    op(4'b0000, '0, '0, 1, 2'd0, 8'd0, "R9 clear");
    op(4'b1101, {2'd0, 2'd0, 2'd0, 2'd0}, {8'd1, 8'd1, 8'd0, 8'd1}, 0, 0, 0, "R9 compaction");
    op(4'b0001, {2'd0, 2'd0, 2'd0, 2'd0}, '0, 0, 0, 0, "R9 count");
    idle_cycle();
    idle_cycle();
    read_all("R10 final");
    idle_cycle();
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule